// File: doc/BRIEF.md
# Double-Ended PWM Steering with Complementary Rectifier Outputs

This block drives two alternating switch outputs, A and B, and two rectifier outputs, AN and BN. A counter oscillator sets the timing. Each oscillator period has a charge interval of `chargeLen` clocks, in which one output may pulse, and a dead interval of `deadLen` clocks, in which neither may. The counter value during the charge interval acts as a digital ramp. A pulse lasts as long as the ramp is below the error word minus a fixed zero-duty threshold. A steering bit flips at the end of every period, so A and B take turns. A full switching cycle therefore spans two oscillator periods.

AN is the complement of A and BN is the complement of B. At the board level, A is paired with BN and B with AN, so both rectifiers conduct while both switches are off. A signed delay code moves the rectifier edges against the switch edges:
- A positive code delays the rectifier outputs.
- A negative code delays the switch outputs. This delay is clamped to 90 % of the dead interval.
- A code in a small dead zone gives no shift.

Each output passes through its own tapped delay line, so a shifted pulse keeps its width. An external terminate pulse ends the active pulse for the rest of its period. An inhibit input forces every output low and restarts steering on A.

Top module: `pwm_steer_top`

## Requirements
- R1: The oscillator period is `chargeLen + deadLen` clocks. Output A pulses in one period and output B in the next, so A rises every `2*(chargeLen+deadLen)` clocks and B rises one period after A. The first pulse after reset is on A.
- R2: A and B are never high in the same clock.
- R3: With no shift, each pulse is high for `min(errWord - 8, chargeLen)` clocks, with a zero-duty threshold of 8. No pulse starts or continues in the dead interval, so B rises `deadLen` clocks after a full-width A pulse ends.
- R4: Steering flips at the end of every period whether or not that period produced a pulse. A pulse resumed after skipped periods lands on the output given by period parity, and pulses at minimum width strictly alternate A, B, A, B.
- R5: When `errWord <= 8`, A and B stay low and AN and BN stay high.
- R6: When the delay code is in the dead zone (|code| <= 1), AN equals the inverse of A and BN equals the inverse of B in every clock. In reset, A=B=0 and AN=BN=1.
- R7: For |code| >= 2, the shift is d = 2 + floor(13*m*m/196) clocks, with m = min(|code|-2, 14). A positive code makes AN fall d clocks after A rises. A negative code makes A rise d clocks after AN falls. For example, code 2 gives 2, code 8 gives 4 and code 15 gives 13.
- R8: For a negative code, the switch delay is limited to floor(9*deadLen/10) clocks.
- R9: A shifted pulse keeps its unshifted width on both the switch output and the rectifier output.
- R10: A terminate sampled high during a pulse drives that output low from the next clock until the end of the period. The following periods pulse at full width.
- R11: While `inhibit` is high, all four outputs are low. After release, the first pulse is on A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| errWord | input | CNT_W | Error word compared against the ramp |
| chargeLen | input | CNT_W | Charge interval length in clocks (>= 1) |
| deadLen | input | CNT_W | Dead interval length in clocks (>= 1) |
| dlyCode | input | DLY_W | Signed rectifier delay/advance code |
| terminate | input | 1 | Ends the active pulse for the rest of the period |
| inhibit | input | 1 | Forces all outputs low and restarts steering |
| outA | output | 1 | Switch output A |
| outB | output | 1 | Switch output B |
| outAN | output | 1 | Rectifier output, inverse of A |
| outBN | output | 1 | Rectifier output, inverse of B |

## Verification
The properties assume that `chargeLen` and `deadLen` are at least one and are held constant while the oscillator runs. They also assume the delay code changes only while the block is in reset, so that each delay line holds a history taken under a single shift. Every scenario in the stimulus programs the lengths and the code before releasing reset and leaves them alone afterwards. The stimulus changes only the error word, terminate and inhibit mid-run, and it drives them at the falling edge. The dead interval is always at least three clocks, which leaves room to resume the error word inside a known dead interval.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  // strobes from the oscillator control to the pulse datapath
  typedef struct packed {
    logic charging; // oscillator is in its charge interval
    logic sideB;    // steering: 0 selects A, 1 selects B
    logic cutOff;   // terminate seen in this period
  } steerStrobe_t;
endpackage

// File: rtl/pwm_steer_ctrl.sv
module pwm_steer_ctrl
  import pwm_steer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inhibit,
  input  logic             terminate,
  input  logic [CNT_W-1:0] chargeLen,
  input  logic [CNT_W-1:0] deadLen,
  output steerStrobe_t     strobe,
  output logic [CNT_W-1:0] rampVal
);
  logic [CNT_W-1:0] cnt;
  logic inDead, sideB, cutOff;
  logic lastCharge, lastDead;

  assign lastCharge = (cnt == chargeLen - 1'b1);
  assign lastDead   = (cnt == deadLen - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || inhibit) begin
      cnt    <= '0;
      inDead <= 1'b0;
      sideB  <= 1'b0;
      cutOff <= 1'b0;
    end else if (!inDead) begin
      if (terminate) cutOff <= 1'b1;
      if (lastCharge) begin
        inDead <= 1'b1;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (lastDead) begin
        inDead <= 1'b0;
        cnt    <= '0;
        sideB  <= ~sideB;  // flips every period, pulse or not
        cutOff <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign strobe.charging = !inDead;
  assign strobe.sideB    = sideB;
  assign strobe.cutOff   = cutOff;
  assign rampVal         = cnt;
endmodule

// File: rtl/pwm_steer_dp.sv
module pwm_steer_dp
  import pwm_steer_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DLY_W     = 5,
  parameter int ZERO_THR  = 8,
  parameter int DEAD_ZONE = 1,
  parameter int MIN_SH    = 2,
  parameter int MAX_SH    = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inhibit,
  input  logic                    terminate,
  input  steerStrobe_t            strobe,
  input  logic [CNT_W-1:0]        rampVal,
  input  logic [CNT_W-1:0]        errWord,
  input  logic [CNT_W-1:0]        deadLen,
  input  logic signed [DLY_W-1:0] dlyCode,
  output logic [1:0]              rawPwm,
  output logic                    outA,
  output logic                    outB,
  output logic                    outAN,
  output logic                    outBN
);
  localparam int NTAP     = MAX_SH + 1;
  localparam int TAP_W    = $clog2(NTAP);
  localparam int MAG_MAX  = 2 ** (DLY_W - 1);
  localparam int M_SPAN   = MAG_MAX - DEAD_ZONE - 1;
  localparam int SPAN_SQ  = M_SPAN * M_SPAN;
  localparam int SH_RANGE = MAX_SH - MIN_SH;

  logic [CNT_W-1:0] dutyCnt;
  logic pulseOn;

  assign dutyCnt = (errWord > CNT_W'(ZERO_THR)) ? errWord - CNT_W'(ZERO_THR) : '0;
  assign pulseOn = strobe.charging && (rampVal < dutyCnt) && !strobe.cutOff && !terminate;

  always_ff @(posedge clk) begin
    if (!rst_n || inhibit) rawPwm <= 2'b00;
    else                   rawPwm <= {pulseOn && strobe.sideB, pulseOn && !strobe.sideB};
  end

  // nonlinear code-to-shift map with dead zone and dead-time clamp
  int mag, mIdx, shRaw, shLim;
  logic [TAP_W-1:0] pwmTap, srTap;

  always_comb begin
    mag = (dlyCode < 0) ? -int'(dlyCode) : int'(dlyCode);
    if (mag <= DEAD_ZONE) begin
      mIdx  = 0;
      shRaw = 0;
    end else begin
      mIdx  = (mag - DEAD_ZONE - 1 > M_SPAN) ? M_SPAN : mag - DEAD_ZONE - 1;
      shRaw = MIN_SH + (mIdx * mIdx * SH_RANGE) / SPAN_SQ;
    end
    shLim = (int'(deadLen) * 9) / 10;
    if (dlyCode < 0) begin
      pwmTap = TAP_W'((shRaw > shLim) ? shLim : shRaw);
      srTap  = '0;
    end else begin
      pwmTap = '0;
      srTap  = TAP_W'(shRaw);
    end
  end

  logic [1:0] pwmV, srV;

  for (genvar ch = 0; ch < 2; ch++) begin : g_line
    logic [NTAP-2:0] hist;
    logic [NTAP-1:0] line;
    always_ff @(posedge clk) begin
      if (!rst_n || inhibit) hist <= '0;
      else                   hist <= {hist[NTAP-3:0], rawPwm[ch]};
    end
    assign line     = {hist, rawPwm[ch]};
    assign pwmV[ch] = line[pwmTap];
    assign srV[ch]  = line[srTap];
  end

  assign outA  = !inhibit && pwmV[0];
  assign outB  = !inhibit && pwmV[1];
  assign outAN = !inhibit && !srV[0];
  assign outBN = !inhibit && !srV[1];
endmodule

// File: rtl/pwm_steer_top.sv
module pwm_steer_top
  import pwm_steer_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DLY_W     = 5,
  parameter int ZERO_THR  = 8,
  parameter int DEAD_ZONE = 1,
  parameter int MIN_SH    = 2,
  parameter int MAX_SH    = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        errWord,
  input  logic [CNT_W-1:0]        chargeLen,
  input  logic [CNT_W-1:0]        deadLen,
  input  logic signed [DLY_W-1:0] dlyCode,
  input  logic                    terminate,
  input  logic                    inhibit,
  output logic                    outA,
  output logic                    outB,
  output logic                    outAN,
  output logic                    outBN
);
  steerStrobe_t     strobe;
  logic [CNT_W-1:0] rampVal;
  logic [1:0]       rawPwm;

  pwm_steer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .terminate(terminate),
    .chargeLen(chargeLen), .deadLen(deadLen), .strobe(strobe), .rampVal(rampVal)
  );

  pwm_steer_dp #(
    .CNT_W(CNT_W), .DLY_W(DLY_W), .ZERO_THR(ZERO_THR),
    .DEAD_ZONE(DEAD_ZONE), .MIN_SH(MIN_SH), .MAX_SH(MAX_SH)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .terminate(terminate),
    .strobe(strobe), .rampVal(rampVal), .errWord(errWord), .deadLen(deadLen),
    .dlyCode(dlyCode), .rawPwm(rawPwm),
    .outA(outA), .outB(outB), .outAN(outAN), .outBN(outBN)
  );
endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk
  import pwm_steer_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int ZERO_THR = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inhibit,
  input logic             terminate,
  input logic [CNT_W-1:0] errWord,
  input steerStrobe_t     strobe,
  input logic [1:0]       rawPwm,
  input logic             outA,
  input logic             outB,
  input logic             outAN,
  input logic             outBN
);
  p_one_side_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rawPwm));

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(outA && outB));

  p_dead_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.charging |=> (rawPwm == 2'b00));

  p_steer_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!inhibit && $past(!inhibit) && $rose(strobe.charging)) |-> (strobe.sideB != $past(strobe.sideB)));

  p_zero_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (errWord <= CNT_W'(ZERO_THR)) |=> (rawPwm == 2'b00));

  p_term_now_r10: assert property (@(posedge clk) disable iff (!rst_n)
    terminate |=> (rawPwm == 2'b00));

  p_cut_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.cutOff && strobe.charging) |=> (rawPwm == 2'b00));

  p_inhibit_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> (!outA && !outB && !outAN && !outBN));
endmodule

bind pwm_steer_top pwm_steer_chk #(.CNT_W(CNT_W), .ZERO_THR(ZERO_THR)) u_chk (.*);

// File: tb/tb_pwm_steer_top.sv
module tb_pwm_steer_top;
  localparam int CNT_W = 8;
  localparam int DLY_W = 5;
  localparam int THR   = 8;
  localparam int CAP   = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] errWord = '0, chargeLen = 8'd10, deadLen = 8'd6;
  logic signed [DLY_W-1:0] dlyCode = '0;
  logic terminate = 1'b0, inhibit = 1'b0;
  logic outA, outB, outAN, outBN;

  int checks = 0, failures = 0;
  bit cA [0:CAP-1];
  bit cB [0:CAP-1];
  bit cAN[0:CAP-1];
  bit cBN[0:CAP-1];

  always #10 clk = ~clk;

  pwm_steer_top dut (
    .clk(clk), .rst_n(rst_n), .errWord(errWord), .chargeLen(chargeLen),
    .deadLen(deadLen), .dlyCode(dlyCode), .terminate(terminate), .inhibit(inhibit),
    .outA(outA), .outB(outB), .outAN(outAN), .outBN(outBN)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(int cl, int dl, int err, int code);
    rst_n = 1'b0; inhibit = 1'b0; terminate = 1'b0;
    chargeLen = CNT_W'(cl); deadLen = CNT_W'(dl);
    errWord = CNT_W'(err); dlyCode = DLY_W'(code);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic capture();
    for (int i = 0; i < CAP; i++) begin
      @(negedge clk);
      cA[i] = outA; cB[i] = outB; cAN[i] = outAN; cBN[i] = outBN;
    end
  endtask

  function automatic bit getS(int sel, int i);
    case (sel)
      0: return cA[i];
      1: return cB[i];
      2: return cAN[i];
      default: return cBN[i];
    endcase
  endfunction

  function automatic int edgeAt(int sel, int from, bit rise);
    for (int i = (from < 0 ? 0 : from) + 1; i < CAP; i++)
      if (getS(sel, i) == rise && getS(sel, i-1) != rise) return i;
    return -1;
  endfunction

  function automatic int runLen(int sel, int from, bit val);
    int n = 0;
    if (from < 0) return 0;
    for (int i = from; i < CAP; i++) begin
      if (getS(sel, i) != val) break;
      n++;
    end
    return n;
  endfunction

  function automatic int expShift(int code, int dl);
    int mg = code < 0 ? -code : code;
    int m, d;
    if (mg <= 1) return 0;
    m = (mg - 2 > 14) ? 14 : mg - 2;
    d = 2 + (13 * m * m) / 196;
    if (code < 0 && d > (9 * dl) / 10) d = (9 * dl) / 10;
    return d;
  endfunction

  task automatic testReset();
    rst_n = 1'b0;
    @(negedge clk);
    chk({outA, outB, outAN, outBN} == 4'b0011, "R6 reset outputs",
        int'({outA, outB, outAN, outBN}), 3);
  endtask

  task automatic testPeriod();
    int ia1, ia2, ib, ovl = 0, mis = 0;
    doReset(10, 6, THR + 5, 0);
    capture();
    ia1 = edgeAt(0, 0, 1'b1);
    ib  = edgeAt(1, ia1, 1'b1);
    ia2 = edgeAt(0, ia1, 1'b1);
    chk(ia2 - ia1 == 32, "R1 A repeat interval", ia2 - ia1, 32);
    chk(ib - ia1 == 16, "R1 B follows A by one period", ib - ia1, 16);
    chk(ib > 0 && edgeAt(0, 0, 1'b1) < ib, "R1 first pulse on A", ia1, ib);
    chk(runLen(0, ia1, 1'b1) == 5, "R3 width from error word", runLen(0, ia1, 1'b1), 5);
    for (int i = 0; i < CAP; i++) begin
      if (cA[i] && cB[i]) ovl++;
      if (cAN[i] == cA[i] || cBN[i] == cB[i]) mis++;
    end
    chk(ovl == 0, "R2 A and B overlap", ovl, 0);
    chk(mis == 0, "R6 complement mismatch", mis, 0);
  endtask

  task automatic testSaturate();
    int ia, fa, ib;
    doReset(10, 6, 200, 0);
    capture();
    ia = edgeAt(0, 0, 1'b1);
    fa = edgeAt(0, ia, 1'b0);
    ib = edgeAt(1, fa, 1'b1);
    chk(fa - ia == 10, "R3 width saturates at charge length", fa - ia, 10);
    chk(ib - fa == 6, "R3 dead interval before B", ib - fa, 6);
  endtask

  task automatic testZeroDuty();
    int hi = 0, lo = 0;
    doReset(10, 6, THR, 0);
    capture();
    for (int i = 0; i < CAP; i++) begin
      if (cA[i] || cB[i]) hi++;
      if (!cAN[i] || !cBN[i]) lo++;
    end
    chk(hi == 0, "R5 switch outputs at zero duty", hi, 0);
    chk(lo == 0, "R5 rectifier outputs at full duty", lo, 0);
  endtask

  task automatic testSkip();
    bit pa, pb;
    int first = -1, lastSide = -1, repeats = 0, npulse = 0;
    doReset(10, 6, THR + 5, 0);
    do @(negedge clk); while (!outA);
    errWord = '0;
    repeat (2 * 16 - 3) @(negedge clk);  // inside dead interval of the skipped B period
    errWord = CNT_W'(THR + 5);
    pa = outA; pb = outB;
    for (int i = 0; i < 100 && first < 0; i++) begin
      @(negedge clk);
      if (outA && !pa) first = 0;
      else if (outB && !pb) first = 1;
      pa = outA; pb = outB;
    end
    chk(first == 0, "R4 side after skipped periods", first, 0);
    doReset(10, 6, THR + 1, 0);
    capture();
    for (int i = 1; i < CAP; i++) begin
      int side = -1;
      if (cA[i] && !cA[i-1]) side = 0;
      if (cB[i] && !cB[i-1]) side = 1;
      if (side >= 0) begin
        if (side == lastSide) repeats++;
        lastSide = side;
        npulse++;
      end
    end
    chk(repeats == 0 && npulse > 10, "R4 strict alternation at minimum width", repeats, 0);
  endtask

  task automatic testShift(int code, int dl);
    int ia, fn, d, wA, wN;
    int exp = expShift(code, dl);
    doReset(10, dl, THR + 5, code);
    capture();
    if (code >= 0) begin
      ia = edgeAt(0, 0, 1'b1);
      fn = edgeAt(2, ia - 1, 1'b0);
      d  = fn - ia;
    end else begin
      fn = edgeAt(2, 0, 1'b0);
      ia = edgeAt(0, fn - 1, 1'b1);
      d  = ia - fn;
    end
    if (code < -8) chk(d == exp, "R8 clamped switch delay", d, exp);
    else           chk(d == exp, "R7 shift from delay code", d, exp);
    wA = runLen(0, ia, 1'b1);
    wN = runLen(2, fn, 1'b0);
    chk(wA == 5 && wN == 5, "R9 width kept under shift", wA * 100 + wN, 505);
  endtask

  task automatic testDeadZone();
    int mis = 0;
    doReset(10, 6, THR + 5, 1);
    capture();
    for (int i = 0; i < CAP; i++) if (cAN[i] == cA[i]) mis++;
    chk(mis == 0, "R7 dead-zone code gives no shift", mis, 0);
  endtask

  task automatic testTerminate();
    int hiCnt = 1, late = 0, wB = 0, wA = 0;
    doReset(20, 6, THR + 15, 0);
    do @(negedge clk); while (!outA);
    repeat (3) begin
      @(negedge clk);
      if (outA) hiCnt++;
    end
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    if (outA) late++;
    repeat (19) begin
      @(negedge clk);
      if (outA) late++;
    end
    chk(hiCnt == 4, "R10 pulse before terminate", hiCnt, 4);
    chk(late == 0, "R10 held off for rest of period", late, 0);
    do @(negedge clk); while (!outB);
    while (outB) begin wB++; @(negedge clk); end
    do @(negedge clk); while (!outA);
    while (outA) begin wA++; @(negedge clk); end
    chk(wB == 15 && wA == 15, "R10 later periods full width", wB * 100 + wA, 1515);
  endtask

  task automatic testInhibit();
    int bad = 0, first = -1;
    bit pa, pb;
    doReset(10, 6, THR + 5, 0);
    do @(negedge clk); while (!outB);
    inhibit = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (outA || outB || outAN || outBN) bad++;
    end
    chk(bad == 0, "R11 outputs low while inhibited", bad, 0);
    inhibit = 1'b0;
    pa = 1'b0; pb = 1'b0;
    for (int i = 0; i < 100 && first < 0; i++) begin
      @(negedge clk);
      if (outA && !pa) first = 0;
      else if (outB && !pb) first = 1;
      pa = outA; pb = outB;
    end
    chk(first == 0, "R11 first pulse on A after release", first, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testPeriod();
    testSaturate();
    testZeroDuty();
    testSkip();
    testShift(8, 10);
    testShift(15, 10);
    testShift(2, 10);
    testShift(-8, 10);
    testShift(-16, 10);
    testDeadZone();
    testTerminate();
    testInhibit();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule